// File: doc/BRIEF.md
# Stop Mode Recovery Controller

This block governs the low-power stop state of a small microcontroller system. The CPU issues a one-cycle stop request. The block then drops the clock enable that gates the CPU and peripheral clocks, and it holds its recovery counter at zero. The stop state ends on a wake-up event: an interrupt request, a break request, or reset.

After an interrupt or break wake-up, the counter runs on the free-running input clock for a recovery delay. A configuration bit picks the delay: a long delay suits crystal startup and a short one suits canned oscillators. When the delay expires, the clock enable returns and a one-cycle strobe tells the CPU it may begin interrupt stacking.

A break wake-up also sets a sticky status flag. Software clears that flag with a one-cycle clear input. Reset is asynchronous. It returns the block to the run state at once, with no recovery delay.

Top module: `stop_recovery_ctrl`

## Requirements
- R1: While in the stop state, `clock_en` and `recovering` are both 0. The recovery counter stays at zero for the whole stop state.
- R2: An `irq_req` pulse during the stop state raises `recovering` on the next clock edge.
- R3: With `fast_rec_cfg` = 0 at the start of recovery, `recovering` stays high for exactly LONG_DELAY (default 4096) input-clock cycles.
- R4: With `fast_rec_cfg` = 1 at the start of recovery, `recovering` stays high for exactly SHORT_DELAY (default 32) cycles.
- R5: A `brk_req` that ends the stop state sets `brk_stop_flag` one cycle later. An interrupt wake-up leaves the flag unchanged.
- R6: `brk_stop_flag` stays set until either a `flag_clr` pulse or reset clears it. A break wake-up in the same cycle as `flag_clr` leaves the flag set.
- R7: `recovery_done` is a one-cycle pulse. It is high in the first cycle in which `clock_en` is 1 again, and it never comes before the full selected delay.
- R8: Asserting `rst_n` low at once sets `clock_en` = 1, `recovering` = 0, `recovery_done` = 0 and `brk_stop_flag` = 0, with no clock edge needed.
- R9: `fast_rec_cfg` is sampled when recovery starts. A change to it during recovery does not change the delay already running.
- R10: A wake-up event in the same cycle as `stop_req` is honored. The block enters recovery on that edge and does not remain stopped.
- R11: `irq_req` and `brk_req` have no effect in the run state without `stop_req`. `stop_req`, `irq_req` and `brk_req` have no effect during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock, also present in stop |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| irq_req | input | 1 | Any enabled interrupt request (wake-up source) |
| brk_req | input | 1 | Break request (wake-up source) |
| fast_rec_cfg | input | 1 | 1 selects the short recovery delay, 0 selects the long one |
| flag_clr | input | 1 | One-cycle software clear of the break-stop flag |
| clock_en | output | 1 | Enable for the CPU and peripheral clocks |
| recovering | output | 1 | High while the recovery delay is running |
| recovery_done | output | 1 | One-cycle strobe that permits interrupt stacking |
| brk_stop_flag | output | 1 | Sticky flag: a break ended the stop state |

## Verification
The assertions check these properties on every cycle:
- The enable is off and the counter is at zero in stop.
- The counter advances by one each cycle during recovery.
- The latched delay limit is stable during recovery.
- The done strobe lasts one cycle, coincides with the enable returning, and follows a counter value one below the limit.
- The flag is set after a break wake-up and holds until it is cleared.

Only the bench scenarios can show the rest:
- The absolute delay lengths of 4096 and 32.
- The configuration bit changing during recovery.
- Wake-up in the same cycle as the stop request.
- Wake-up inputs being ignored in the run state.
- Asynchronous reset in mid-recovery.

Each scenario is compared against a behavioural reference model.

// File: rtl/src_pkg.sv
package src_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STOP    = 2'd1,
    ST_RECOVER = 2'd2
  } src_state_e;

  // Number of input-clock cycles the recovery window lasts.
  function automatic int unsigned rec_len(input logic fast,
                                          input int unsigned long_d,
                                          input int unsigned short_d);
    return fast ? short_d : long_d;
  endfunction

endpackage

// File: rtl/src_fsm.sv
module src_fsm
  import src_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wake,
  input  logic       rec_expire,
  output src_state_e state,
  output logic       rec_start
);

  src_state_e nxt;

  always_comb begin
    nxt       = state;
    rec_start = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (stop_req) begin
          if (wake) begin
            nxt       = ST_RECOVER;
            rec_start = 1'b1;
          end else begin
            nxt = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (wake) begin
          nxt       = ST_RECOVER;
          rec_start = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (rec_expire) nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

endmodule

// File: rtl/src_counter.sv
module src_counter
  import src_pkg::*;
#(
  parameter int unsigned LONG_DELAY  = 4096,
  parameter int unsigned SHORT_DELAY = 32,
  parameter int unsigned CW          = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rec_start,
  input  logic          fast_cfg,
  output logic          expire,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] lim
);

  // The limit is captured once, when recovery begins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lim <= CW'(LONG_DELAY);
    else if (rec_start) lim <= CW'(rec_len(fast_cfg, LONG_DELAY, SHORT_DELAY));
  end

  // The count is held at zero outside the recovery window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else          cnt <= cnt + CW'(1);
  end

  assign expire = run && (cnt == lim - CW'(1));

endmodule

// File: rtl/src_flag.sv
module src_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/stop_recovery_ctrl.sv
module stop_recovery_ctrl
  import src_pkg::*;
#(
  parameter int unsigned LONG_DELAY  = 4096,
  parameter int unsigned SHORT_DELAY = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic irq_req,
  input  logic brk_req,
  input  logic fast_rec_cfg,
  input  logic flag_clr,
  output logic clock_en,
  output logic recovering,
  output logic recovery_done,
  output logic brk_stop_flag
);

  localparam int unsigned CNT_W = $clog2(LONG_DELAY + 1);

  // Internal events brought out as named wires for the assertions.
  src_state_e       st;
  logic             wake;
  logic             rec_start;
  logic             rec_expire;
  logic             brk_wake;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign wake     = irq_req | brk_req;
  assign brk_wake = brk_req && ((st == ST_STOP) || (st == ST_RUN && stop_req));

  src_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .wake       (wake),
    .rec_expire (rec_expire),
    .state      (st),
    .rec_start  (rec_start)
  );

  src_counter #(
    .LONG_DELAY  (LONG_DELAY),
    .SHORT_DELAY (SHORT_DELAY),
    .CW          (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (st == ST_RECOVER),
    .rec_start (rec_start),
    .fast_cfg  (fast_rec_cfg),
    .expire    (rec_expire),
    .cnt       (cnt),
    .lim       (lim)
  );

  src_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (brk_wake),
    .clr   (flag_clr),
    .flag  (brk_stop_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recovery_done <= 1'b0;
    else        recovery_done <= rec_expire;
  end

  assign clock_en   = (st == ST_RUN);
  assign recovering = (st == ST_RECOVER);

endmodule

module src_checker
  import src_pkg::*;
#(
  parameter int unsigned CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input src_state_e    st,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim,
  input logic          clock_en,
  input logic          recovering,
  input logic          recovery_done,
  input logic          brk_stop_flag,
  input logic          flag_clr,
  input logic          brk_wake,
  input logic          rec_expire
);

  // R1
  stop_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP) |-> (!clock_en && !recovering && cnt == '0));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && !rec_expire) |=> (cnt == $past(cnt) + CW'(1)));

  // R9
  lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && $past(recovering)) |-> $stable(lim));

  // R7
  done_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_done |-> (clock_en && $past(recovering)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_done |=> !recovery_done);

  // R7
  done_full_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_done |-> ($past(cnt) == $past(lim) - CW'(1)));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_wake |=> brk_stop_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_stop_flag && !flag_clr) |=> brk_stop_flag);

endmodule

bind stop_recovery_ctrl src_checker #(.CW(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st            (st),
  .cnt           (cnt),
  .lim           (lim),
  .clock_en      (clock_en),
  .recovering    (recovering),
  .recovery_done (recovery_done),
  .brk_stop_flag (brk_stop_flag),
  .flag_clr      (flag_clr),
  .brk_wake      (brk_wake),
  .rec_expire    (rec_expire)
);

// File: tb/tb_stop_recovery_ctrl.sv
`timescale 1ns/1ps
module tb_stop_recovery_ctrl;

  localparam int LONG_D  = 4096;
  localparam int SHORT_D = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, irq_req = 1'b0, brk_req = 1'b0;
  logic fast_rec_cfg = 1'b0, flag_clr = 1'b0;
  logic clock_en, recovering, recovery_done, brk_stop_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  stop_recovery_ctrl #(.LONG_DELAY(LONG_D), .SHORT_DELAY(SHORT_D)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req),
    .brk_req(brk_req), .fast_rec_cfg(fast_rec_cfg), .flag_clr(flag_clr),
    .clock_en(clock_en), .recovering(recovering),
    .recovery_done(recovery_done), .brk_stop_flag(brk_stop_flag)
  );

  // Behavioural reference model: 0 run, 1 stop, 2 recovering.
  int m_mode = 0;
  int m_left = 0;
  bit m_done = 0;
  bit m_flag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_done = 0; m_flag = 0;
    end else begin
      bit woke_brk;
      woke_brk = brk_req && (m_mode == 1 || (m_mode == 0 && stop_req));
      m_done = 0;
      if (m_mode == 0) begin
        if (stop_req) begin
          if (irq_req || brk_req) begin
            m_mode = 2; m_left = fast_rec_cfg ? SHORT_D : LONG_D;
          end else m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (irq_req || brk_req) begin
          m_mode = 2; m_left = fast_rec_cfg ? SHORT_D : LONG_D;
        end
      end else begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_mode = 0; m_done = 1; end
      end
      if (woke_brk) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    check("R1 clock_en vs model", clock_en, m_mode == 0);
    check("R3 recovering vs model", recovering, m_mode == 2);
    check("R7 recovery_done vs model", recovery_done, m_done);
    check("R5 brk_stop_flag vs model", brk_stop_flag, m_flag);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; tick(); stop_req = 1'b0;
  endtask

  // Counts cycles with recovering high until the done strobe appears.
  task automatic wait_done(output int n, input bit poke_mid);
    n = recovering ? 1 : 0;
    for (int i = 0; i < 10000 && !recovery_done; i++) begin
      if (poke_mid && i == 10) begin
        fast_rec_cfg = ~fast_rec_cfg;
        stop_req = 1'b1; irq_req = 1'b1; brk_req = 1'b1;
      end
      tick();
      stop_req = 1'b0; irq_req = 1'b0; brk_req = 1'b0;
      if (recovering) n++;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    // Reset state (R8)
    repeat (3) @(negedge clk);
    check("R8 reset clock_en", clock_en, 1'b1);
    check("R8 reset recovering", recovering, 1'b0);
    check("R8 reset flag", brk_stop_flag, 1'b0);
    rst_n = 1'b1;
    tick();

    // R11: wake inputs ignored in run
    irq_req = 1'b1; brk_req = 1'b1; tick(); irq_req = 1'b0; brk_req = 1'b0;
    tick();
    check("R11 run ignores wake clock_en", clock_en, 1'b1);
    check("R11 run ignores brk flag", brk_stop_flag, 1'b0);

    // R1/R2/R3/R9/R11: long recovery, cfg flips and stray requests mid-way
    fast_rec_cfg = 1'b0;
    pulse_stop();
    repeat (5) tick();
    check("R1 stop clock_en off", clock_en, 1'b0);
    check("R1 stop not recovering", recovering, 1'b0);
    irq_req = 1'b1; tick(); irq_req = 1'b0;
    check("R2 irq wake starts recovery", recovering, 1'b1);
    wait_done(n, 1'b1);
    check_int("R3 R9 long delay length", n, LONG_D);
    check("R7 done with clock_en", clock_en, 1'b1);
    check("R11 recovery ignores brk flag", brk_stop_flag, 1'b0);
    tick();
    check("R7 done one cycle", recovery_done, 1'b0);

    // R4/R9: short recovery, cfg flips back mid-way
    fast_rec_cfg = 1'b1;
    pulse_stop(); tick();
    irq_req = 1'b1; tick(); irq_req = 1'b0;
    wait_done(n, 1'b1);
    check_int("R4 R9 short delay length", n, SHORT_D);
    check("R5 irq wake leaves flag", brk_stop_flag, 1'b0);
    tick();

    // R5/R6: break wake sets flag, sticky, then cleared
    fast_rec_cfg = 1'b1;
    pulse_stop(); tick();
    brk_req = 1'b1; tick(); brk_req = 1'b0;
    check("R5 brk flag set", brk_stop_flag, 1'b1);
    wait_done(n, 1'b0);
    check_int("R5 brk wake delay", n, SHORT_D);
    repeat (4) tick();
    check("R6 flag sticky", brk_stop_flag, 1'b1);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    check("R6 flag cleared", brk_stop_flag, 1'b0);

    // R6: set wins over clear; R10: wake with stop request
    stop_req = 1'b1; brk_req = 1'b1; flag_clr = 1'b1; tick();
    stop_req = 1'b0; brk_req = 1'b0; flag_clr = 1'b0;
    check("R10 same-cycle wake enters recovery", recovering, 1'b1);
    check("R6 set wins over clear", brk_stop_flag, 1'b1);
    wait_done(n, 1'b0);
    check_int("R10 same-cycle wake delay", n, SHORT_D);
    tick();

    // R8: asynchronous reset mid-recovery
    fast_rec_cfg = 1'b0;
    pulse_stop();
    irq_req = 1'b1; tick(); irq_req = 1'b0;
    repeat (7) tick();
    #1 rst_n = 1'b0;
    #1;
    check("R8 async clock_en", clock_en, 1'b1);
    check("R8 async recovering", recovering, 1'b0);
    check("R8 async flag", brk_stop_flag, 1'b0);
    check("R8 async done", recovery_done, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick();
    check("R8 stays in run", clock_en, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule